// File: doc/BRIEF.md
# Phase-Frequency Detector with Reference Divider and Pump Current Control

This block is the digital front end of a PLL synthesizer. It samples a reference clock and the already-divided VCO feedback on a fast system clock. It divides the reference by a programmable 14-bit ratio and compares the result with the feedback in a two-flop phase-frequency detector. The detector produces UP and DOWN pulses whose widths follow the phase and frequency error. The block also presents the charge-pump current code and the output-enable control that an analog pump would use.

Software writes three configuration words through a simple write port. The first sets the divide ratio, the second sets the pump current code, and the third holds the standby bit and the fast-acquire settings. Each write to the divide ratio marks a channel change. When fast acquire is enabled, the block then forces the maximum current code for a programmable number of divided-reference cycles, so the loop settles faster. The block comes out of reset in standby: the pump output is disabled and both pulses are held low.

Top module: `pfd_synth_core`

## Requirements
- R1: After reset, up, dn, acq_boost and pump_oe are 0 and pump_code is 0, because the standby bit resets to 1.
- R2: The control word is written with cfg_sel=2, and its bit 0 is the standby bit. While standby is 1, up, dn and pump_oe are 0 from the cycle after the write. While standby is 0, pump_oe is 1.
- R3: The divide ratio is written with cfg_sel=0 into bits 13:0, and each such write restarts the divider. Ratio values 0 and 1 make every rising reference edge count. A ratio R≥2 makes only every R-th rising reference edge after the write count.
- R4: A counted reference edge sets up in the clock cycle where it is first sampled, and up stays high until a clear. A rising feedback edge does the same for dn.
- R5: When up and dn are both high, they are high together for exactly one clock cycle and are then cleared, unless a new edge arrives.
- R6: An edge sampled in the clear cycle is not lost. Its flag is set again while the other flag clears.
- R7: The current code is written with cfg_sel=1 into bits 2:0. Outside a boost, pump_code equals this code, which stands for a pump current of (code+1)×0.625 mA.
- R8: Control bit 1 enables fast acquire, and control bits 15:8 set its length L. A divide-ratio write made while fast acquire is enabled drives pump_code to 7 and acq_boost to 1. Both hold until L counted reference edges have passed.
- R9: A divide-ratio write with fast acquire disabled, or with L=0, produces no boost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference clock, sampled on clk |
| fb_in | input | 1 | Divided VCO feedback, sampled on clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word select: 0 divide ratio, 1 current code, 2 control |
| cfg_wdata | input | 16 | Configuration write data |
| up | output | 1 | Pump-up pulse |
| dn | output | 1 | Pump-down pulse |
| pump_code | output | 3 | Effective pump current code |
| pump_oe | output | 1 | Pump output enable; low means tristate |
| acq_boost | output | 1 | Fast-acquire boost active |

## Verification
The hardest case to reach is a new reference edge that lands in the one cycle where both flags are being cleared. The stimulus reaches it by driving the reference and feedback levels cycle by cycle from the bench. It first raises UP and lets it stand, then raises the feedback. On the very next cycle it raises the reference again, so the rising edge and the clear fall on the same clock edge. The fast-acquire countdown is covered in the same way: divided-reference edges are stepped one at a time while pump_code is watched for the exact cycle in which the boost ends.

// File: rtl/pfd_synth_core.sv
module pfd_synth_core #(
  parameter int RW = 14,
  parameter int CW = 3,
  parameter int LW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic          fb_in,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic          up,
  output logic          dn,
  output logic [CW-1:0] pump_code,
  output logic          pump_oe,
  output logic          acq_boost
);
  localparam logic [1:0]    SEL_DIV  = 2'd0;
  localparam logic [1:0]    SEL_CODE = 2'd1;
  localparam logic [1:0]    SEL_CTRL = 2'd2;
  localparam logic [CW-1:0] CODE_MAX = '1;
  localparam int            LEN_LSB  = 8;

  logic          ref_q, fb_q;
  logic [RW-1:0] r_div, div_cnt;
  logic [CW-1:0] loi;
  logic          sb, fa_en;
  logic [LW-1:0] fa_len, fa_cnt;
  logic          up_q, dn_q;

  wire ref_rise = ref_in & ~ref_q;
  wire fb_rise  = fb_in & ~fb_q;
  wire wr_div   = cfg_we && cfg_sel == SEL_DIV;
  wire pass     = r_div <= RW'(1);
  wire ref_tick = ~sb & ref_rise & (pass | (div_cnt == r_div - RW'(1)));
  wire fb_tick  = ~sb & fb_rise;
  wire both     = up_q & dn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
    end else begin
      ref_q <= ref_in;
      fb_q  <= fb_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_div  <= RW'(1);
      loi    <= '0;
      sb     <= 1'b1;
      fa_en  <= 1'b0;
      fa_len <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_DIV:  r_div <= cfg_wdata[RW-1:0];
        SEL_CODE: loi   <= cfg_wdata[CW-1:0];
        SEL_CTRL: begin
          sb     <= cfg_wdata[0];
          fa_en  <= cfg_wdata[1];
          fa_len <= cfg_wdata[LEN_LSB +: LW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sb || wr_div)
      div_cnt <= '0;
    else if (ref_rise)
      div_cnt <= ref_tick ? '0 : div_cnt + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      fa_cnt <= '0;
    else if (wr_div)
      fa_cnt <= fa_en ? fa_len : '0;
    else if (ref_tick && fa_cnt != '0)
      fa_cnt <= fa_cnt - LW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sb) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= ref_tick | (up_q & ~both);
      dn_q <= fb_tick  | (dn_q & ~both);
    end
  end

  assign up        = up_q & ~sb;
  assign dn        = dn_q & ~sb;
  assign pump_oe   = ~sb;
  assign acq_boost = fa_cnt != '0;
  assign pump_code = acq_boost ? CODE_MAX : loi;
endmodule

// File: rtl/pfd_synth_core_chk.sv
module pfd_synth_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_in,
  input logic       fb_in,
  input logic       cfg_we,
  input logic [1:0] cfg_sel,
  input logic       sb_bit,
  input logic       fa_en,
  input logic       up,
  input logic       dn,
  input logic       pump_oe,
  input logic       acq_boost,
  input logic [2:0] pump_code
);
  AST_STBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd2 && sb_bit) |=> (!up && !dn && !pump_oe)); // R2
  AST_UP_FROM_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> $past(ref_in)); // R4
  AST_DN_FROM_FB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn) |-> $past(fb_in)); // R4
  AST_OVERLAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |=> ((!up || ref_in) && (!dn || fb_in))); // R5
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_boost && !$past(acq_boost) && !$past(cfg_we)) |-> $stable(pump_code)); // R7
  AST_BOOST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_boost) |-> $past(cfg_we && cfg_sel == 2'd0 && fa_en)); // R8
endmodule

bind pfd_synth_core pfd_synth_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .sb_bit(cfg_wdata[0]), .fa_en(fa_en),
  .up(up), .dn(dn), .pump_oe(pump_oe), .acq_boost(acq_boost),
  .pump_code(pump_code)
);

// File: tb/pfd_synth_core_tb_top.sv
module pfd_synth_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_in = 1'b0, fb_in = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic up, dn, pump_oe, acq_boost;
  logic [2:0] pump_code;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] m;
    logic       eu, ed;
    logic [2:0] ec;
    logic       eo, eb;
    string      req;
  } exp_t;
  exp_t q[$];

  pfd_synth_core dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .up(up), .dn(dn), .pump_code(pump_code), .pump_oe(pump_oe),
    .acq_boost(acq_boost)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // mask bits: 0 up, 1 dn, 2 code, 3 oe, 4 boost
  task automatic step(input logic r, input logic f, input logic we,
                      input logic [1:0] sel, input logic [15:0] d,
                      input logic [4:0] m, input logic eu, input logic ed,
                      input logic [2:0] ec, input logic eo, input logic eb,
                      input string req);
    exp_t e;
    @(negedge clk);
    ref_in = r; fb_in = f; cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    e.m = m; e.eu = eu; e.ed = ed; e.ec = ec; e.eo = eo; e.eb = eb; e.req = req;
    q.push_back(e);
  endtask

  task automatic pd(input logic r, input logic f, input logic eu,
                    input logic ed, input string req);
    step(r, f, 1'b0, 2'd0, 16'h0, 5'b00011, eu, ed, 3'd0, 1'b0, 1'b0, req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic bad;
        e = q.pop_front();
        bad = (e.m[0] && up !== e.eu) || (e.m[1] && dn !== e.ed) ||
              (e.m[2] && pump_code !== e.ec) || (e.m[3] && pump_oe !== e.eo) ||
              (e.m[4] && acq_boost !== e.eb);
        checks++;
        if (bad) begin
          errors++;
          $display("FAIL %s: actual up=%b dn=%b code=%0d oe=%b boost=%b expected up=%b dn=%b code=%0d oe=%b boost=%b mask=%b",
                   e.req, up, dn, pump_code, pump_oe, acq_boost,
                   e.eu, e.ed, e.ec, e.eo, e.eb, e.m);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual run still busy expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(0,0,0,2'd0,16'h0, 5'b11111, 0,0,3'd0,0,0, "R1");
    // R2 standby ignores edges
    step(1,0,0,2'd0,16'h0, 5'b01011, 0,0,3'd0,0,0, "R2");
    step(0,1,0,2'd0,16'h0, 5'b01011, 0,0,3'd0,0,0, "R2");
    step(0,0,1,2'd2,16'h0000, 5'b01000, 0,0,3'd0,1,0, "R2");
    // R4/R5 up first, ratio 1
    pd(1,0, 1,0, "R4_up_set");
    pd(1,0, 1,0, "R4_up_hold");
    pd(1,1, 1,1, "R5_overlap");
    pd(1,1, 0,0, "R5_clear");
    pd(0,0, 0,0, "R5_idle");
    // dn first
    pd(0,1, 0,1, "R4_dn_set");
    pd(1,1, 1,1, "R5_overlap_dn");
    pd(1,1, 0,0, "R5_clear_dn");
    pd(0,0, 0,0, "R5_idle");
    // R6 edge in clear cycle
    pd(1,0, 1,0, "R6_up");
    pd(0,0, 1,0, "R6_hold");
    pd(0,1, 1,1, "R6_both");
    pd(1,1, 1,0, "R6_edge_kept");
    pd(1,0, 1,0, "R6_still");
    pd(1,1, 1,1, "R6_both2");
    pd(0,0, 0,0, "R6_clear");
    // R3 ratio 0 passes through, no boost (R9)
    step(0,0,1,2'd0,16'h0000, 5'b10011, 0,0,3'd0,1,0, "R9_noboost_dis");
    pd(1,0, 1,0, "R3_ratio0");
    pd(1,1, 1,1, "R3_ratio0_fb");
    pd(0,0, 0,0, "R3_clear");
    // R3 ratio 3
    step(0,0,1,2'd0,16'd3, 5'b00011, 0,0,3'd0,1,0, "R3_write");
    pd(1,0, 0,0, "R3_edge1");
    pd(0,0, 0,0, "R3_low");
    pd(1,0, 0,0, "R3_edge2");
    pd(0,0, 0,0, "R3_low");
    pd(1,0, 1,0, "R3_edge3");
    pd(1,1, 1,1, "R3_fb");
    pd(0,0, 0,0, "R3_clear");
    // R7 current code
    step(0,0,1,2'd1,16'd5, 5'b10100, 0,0,3'd5,1,0, "R7_code");
    // R8 fast acquire, length 2
    step(0,0,1,2'd2,16'h0202, 5'b11100, 0,0,3'd5,1,0, "R8_setup");
    step(0,0,1,2'd0,16'd1, 5'b10100, 0,0,3'd7,1,1, "R8_boost_on");
    step(1,0,0,2'd0,16'h0, 5'b10101, 1,0,3'd7,1,1, "R8_tick1");
    step(1,1,0,2'd0,16'h0, 5'b10111, 1,1,3'd7,1,1, "R8_hold");
    step(0,0,0,2'd0,16'h0, 5'b10111, 0,0,3'd7,1,1, "R8_hold2");
    step(1,0,0,2'd0,16'h0, 5'b10101, 1,0,3'd5,1,0, "R8_boost_end");
    pd(1,1, 1,1, "R8_fb");
    pd(0,0, 0,0, "R8_clear");
    // R9 length 0
    step(0,0,1,2'd2,16'h0002, 5'b10100, 0,0,3'd5,1,0, "R9_len0_setup");
    step(0,0,1,2'd0,16'd1, 5'b10100, 0,0,3'd5,1,0, "R9_len0");
    // R2 re-entering standby drops pending up
    pd(1,0, 1,0, "R2_pre");
    step(1,0,1,2'd2,16'h0001, 5'b01011, 0,0,3'd0,0,0, "R2_stby");
    step(0,1,0,2'd0,16'h0, 5'b01011, 0,0,3'd0,0,0, "R2_stby_fb");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule